// File: doc/BRIEF.md
# XOR-Indexed Bit Permuter

This block rearranges the bits of a source word. Output bit `j` takes the source bit at position `j XOR k`, where `k` is a small control value. Setting bit `s` of `k` swaps every pair of neighbouring `2^s`-bit groups. `k = 0` therefore leaves the word unchanged. `k` with all bits set reverses the word end to end. Other values of `k` give nibble swaps, byte swaps and similar shuffles.

A 2-bit mode input picks where `k` comes from and how wide the operation is. `k` is taken either from a control register operand or from a short immediate. The operation works either on the whole word or on its lower half. In the half-width modes the upper half of the result is cleared. The result is registered one cycle after the request.

When the request carries a record flag, a 3-bit signed-sign summary of the result is also captured and flagged for one cycle. Decode and operand fetch sit outside this block.

Top module: `grev_permuter`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `cond_valid`, `result` and `cond` are all zero on the next clock edge.
- R2: For a request accepted with `in_valid` high, `result` bit `j` equals the (possibly cleared) source bit `j XOR k`. The result appears with `out_valid` high exactly one clock later.
- R3: With `mode` = 0 (full, register), `k` is `ctrl[LG-1:0]` (LG = log2 XLEN). All higher `ctrl` bits have no effect.
- R4: With `mode` = 1 (full, immediate), `k` is `imm[LG-1:0]` of the 6-bit immediate.
- R5: With `mode` = 2 (half, register), only `src[XLEN/2-1:0]` is permuted, with `k` = `ctrl[LG-2:0]`. `result[XLEN-1:XLEN/2]` is zero.
- R6: With `mode` = 3 (half, immediate), `k` is `imm[LG-2:0]`, the low bits of the 5-bit shift field. `imm[5]` has no effect.
- R7: `k = 0` returns the source unchanged. `k` with all used bits set reverses the bit order of the operated width.
- R8: A request with `record` high raises `cond_valid` together with `out_valid`. `cond` = {negative, positive, zero} is one-hot and judges the registered result as a signed XLEN-bit value.
- R9: A request with `record` low leaves `cond` unchanged and keeps `cond_valid` low.
- R10: A cycle with `in_valid` low drops `out_valid` next cycle and holds `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | 0 full/reg, 1 full/imm, 2 half/reg, 3 half/imm |
| src | input | XLEN | Source word |
| ctrl | input | XLEN | Control register operand |
| imm | input | IMM_W | Immediate control (6 bits) |
| record | input | 1 | Update the condition field |
| out_valid | output | 1 | Result valid |
| result | output | XLEN | Permuted word |
| cond_valid | output | 1 | Condition field updated this cycle |
| cond | output | 3 | {negative, positive, zero} of the result |

## Verification
Half-width clearing and condition generation act in the same cycle. A half-width request with `record` set and the lower-half top bit set is the interesting case. The sign must come from the cleared upper half, so the result must report positive and never negative. The bench issues such requests directly and also through random modes with random record flags. Each `cond` is compared against a sign computed from the bench's own reference result.

// File: rtl/grev_pkg.sv
// Shared types for the XOR-indexed bit permuter.
package grev_pkg;
    typedef enum logic [1:0] {
        GM_FULL_REG = 2'd0,
        GM_FULL_IMM = 2'd1,
        GM_HALF_REG = 2'd2,
        GM_HALF_IMM = 2'd3
    } grev_mode_e;

    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
    } grev_cond_t;
endpackage

// File: rtl/grev_ksel.sv
// Control value selection.
// mode[0] picks the immediate over the register operand; mode[1] selects the
// half-width form, which limits k to log2(XLEN/2) bits.
// Assumes XLEN is a power of two >= 4 and IMM_W >= log2(XLEN).
module grev_ksel #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 6,
    localparam int LG   = $clog2(XLEN)
) (
    input  logic [1:0]      mode,
    input  logic [LG-1:0]   ctrl_lo,
    input  logic [IMM_W-1:0] imm,
    output logic [LG-1:0]   k,
    output logic            half
);
    logic [LG-1:0] raw;
    logic          unused_imm;

    assign unused_imm = ^imm[IMM_W-1:LG-1];

    // Pick the source of k and trim its top bit for half-width forms.
    always_comb begin
        half = mode[1];
        raw  = mode[0] ? imm[LG-1:0] : ctrl_lo;
        k    = half ? {1'b0, raw[LG-2:0]} : raw;
    end
endmodule

// File: rtl/grev_butterfly.sv
// Butterfly network: log2(W) stages, stage s swaps neighbouring 2^s-bit
// groups when k[s] is set. The net effect is out[j] = in[j ^ k].
// Assumes W is a power of two.
module grev_butterfly #(
    parameter int W  = 64,
    localparam int LG = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [LG-1:0] k,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stg [0:LG];

    assign stg[0] = din;

    for (genvar s = 0; s < LG; s++) begin : g_stage
        for (genvar j = 0; j < W; j++) begin : g_bit
            // Take the partner bit when this stage is enabled.
            assign stg[s+1][j] = k[s] ? stg[s][j ^ (1 << s)] : stg[s][j];
        end
    end

    assign dout = stg[LG];
endmodule

// File: rtl/grev_cond.sv
// Signed sign summary of a word: exactly one of neg, pos, zero is set.
module grev_cond #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]        val,
    output grev_pkg::grev_cond_t   cnd
);
    // Classify the value as negative, positive or zero.
    always_comb begin
        cnd.zero = (val == '0);
        cnd.neg  = val[XLEN-1];
        cnd.pos  = !val[XLEN-1] && !cnd.zero;
    end
endmodule

// File: rtl/grev_permuter.sv
// XOR-indexed bit permuter, top level.
// One cycle latency. Half-width modes clear the upper source half before the
// network; since k stays below XLEN/2 there, the upper result half is zero.
// The condition field is captured only for requests with record set.
module grev_permuter #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 6,
    localparam int LG   = $clog2(XLEN),
    localparam int HALF = XLEN / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       mode,
    input  logic [XLEN-1:0]  src,
    input  logic [XLEN-1:0]  ctrl,
    input  logic [IMM_W-1:0] imm,
    input  logic             record,
    output logic             out_valid,
    output logic [XLEN-1:0]  result,
    output logic             cond_valid,
    output logic [2:0]       cond
);
    import grev_pkg::*;

    logic [LG-1:0]   k;
    logic            half;
    logic [XLEN-1:0] src_eff;
    logic [XLEN-1:0] perm;
    grev_cond_t      cnd_next;
    logic            unused_ctrl;

    assign unused_ctrl = ^ctrl[XLEN-1:LG];

    grev_ksel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ksel (
        .mode    (mode),
        .ctrl_lo (ctrl[LG-1:0]),
        .imm     (imm),
        .k       (k),
        .half    (half)
    );

    // Clear the upper source half for half-width forms.
    always_comb begin
        src_eff = half ? {{HALF{1'b0}}, src[HALF-1:0]} : src;
    end

    grev_butterfly #(.W(XLEN)) u_net (
        .din  (src_eff),
        .k    (k),
        .dout (perm)
    );

    grev_cond #(.XLEN(XLEN)) u_cond (
        .val (perm),
        .cnd (cnd_next)
    );

    // Output registers: result and valid follow the request stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= perm;
        end
    end

    // Condition register: updated only on recorded requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_valid <= 1'b0;
            cond       <= '0;
        end else begin
            cond_valid <= in_valid && record;
            if (in_valid && record) cond <= cnd_next;
        end
    end
endmodule

// File: rtl/grev_permuter_chk.sv
// Protocol checker for grev_permuter, attached by bind below.
module grev_permuter_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [1:0]      mode,
    input logic            record,
    input logic            out_valid,
    input logic [XLEN-1:0] result,
    input logic            cond_valid,
    input logic [2:0]      cond
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !cond_valid && result == '0 && cond == '0)); // R1

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result))); // R10

    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[1]) |=> (result[XLEN-1:XLEN/2] == '0)); // R5

    AST_COND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        cond_valid |-> ($countones(cond) == 1 && out_valid)); // R8

    AST_COND_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !record) |=> (!cond_valid && $stable(cond))); // R9
endmodule

bind grev_permuter grev_permuter_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mode       (mode),
    .record     (record),
    .out_valid  (out_valid),
    .result     (result),
    .cond_valid (cond_valid),
    .cond       (cond)
);

// File: tb/grev_permuter_tb.sv
module grev_permuter_tb;
    localparam int XLEN = 64;
    localparam int IW   = 6;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [1:0]      mode;
    logic [XLEN-1:0] src, ctrl;
    logic [IW-1:0]   imm;
    logic            record;
    logic            out_valid, cond_valid;
    logic [XLEN-1:0] result;
    logic [2:0]      cond;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [2:0] exp_cond = 3'b000;

    always #5 clk = ~clk;

    grev_permuter #(.XLEN(XLEN), .IMM_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .src(src), .ctrl(ctrl), .imm(imm), .record(record),
        .out_valid(out_valid), .result(result),
        .cond_valid(cond_valid), .cond(cond)
    );

    // Reference permutation written from the requirements.
    function automatic logic [XLEN-1:0] ref_perm(input logic [1:0] m,
            input logic [XLEN-1:0] s, input logic [XLEN-1:0] c, input logic [IW-1:0] im);
        int width = m[1] ? XLEN/2 : XLEN;
        int kv    = (m[0] ? int'(im) : int'(c[7:0])) % width;
        logic [XLEN-1:0] r = '0;
        for (int i = 0; i < width; i++) r[i] = s[i ^ kv];
        return r;
    endfunction

    function automatic logic [2:0] ref_cond(input logic [XLEN-1:0] v);
        if (v == '0) return 3'b001;
        if (v[XLEN-1]) return 3'b100;
        return 3'b010;
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one request, then check the registered outputs one cycle later.
    task automatic op(input string req, input logic [1:0] m, input logic [XLEN-1:0] s,
            input logic [XLEN-1:0] c, input logic [IW-1:0] im, input logic rec,
            input logic [XLEN-1:0] exp);
        @(negedge clk);
        in_valid = 1'b1; mode = m; src = s; ctrl = c; imm = im; record = rec;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, result, exp);
        check({req, " R2 valid"}, {63'd0, out_valid}, 64'd1);
        if (rec) exp_cond = ref_cond(exp);
        check(rec ? "R8 cond" : "R9 cond kept", {61'd0, cond}, {61'd0, exp_cond});
        check(rec ? "R8 cond_valid" : "R9 cond_valid", {63'd0, cond_valid}, {63'd0, rec});
    endtask

    function automatic logic [XLEN-1:0] rev_full(input logic [XLEN-1:0] v);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN; i++) r[i] = v[XLEN-1-i];
        return r;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] s, c, held;
        logic [IW-1:0] im;
        logic [1:0] m;
        logic rec;
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; in_valid = 1'b0; mode = '0; src = '1; ctrl = '1; imm = '1; record = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 result", result, '0);
        check("R1 flags", {62'd0, out_valid, cond_valid}, 64'd0);
        check("R1 cond", {61'd0, cond}, 64'd0);
        rst_n = 1'b1;

        s = 64'h0123_4567_89ab_cdef;
        op("R7 identity", 2'd0, s, 64'd0, 6'd0, 1'b1, s);
        op("R3 upper ctrl ignored", 2'd0, s, 64'hffff_ffff_ffff_ffc0, 6'd63, 1'b0, s);
        op("R7 full reverse reg", 2'd0, s, 64'd63, 6'd0, 1'b1, rev_full(s));
        op("R4 full reverse imm", 2'd1, s, 64'd0, 6'd63, 1'b0, rev_full(s));
        op("R4 byte swap imm", 2'd1, s, 64'd63, 6'd56, 1'b1, 64'hefcd_ab89_6745_2301);
        op("R5 half reverse", 2'd2, 64'hffff_ffff_0000_0001, 64'd31, 6'd0, 1'b1,
           64'h0000_0000_8000_0000);
        op("R6 imm bit5 ignored", 2'd3, 64'hffff_ffff_0000_0001, 64'd0, 6'd63, 1'b1,
           64'h0000_0000_8000_0000);
        op("R5 half identity", 2'd2, 64'h1234_5678_9abc_def0, 64'd32, 6'd0, 1'b0,
           64'h0000_0000_9abc_def0);
        op("R8 zero result", 2'd0, 64'd0, 64'd5, 6'd0, 1'b1, 64'd0);

        // R10: idle cycle keeps result and drops valid.
        held = result;
        @(negedge clk);
        check("R10 hold", result, held);
        check("R10 valid low", {63'd0, out_valid}, 64'd0);

        for (int n = 0; n < 400; n++) begin
            m   = 2'($urandom_range(0, 3));
            s   = {$urandom, $urandom};
            c   = {$urandom, $urandom};
            im  = 6'($urandom);
            rec = 1'($urandom);
            if (n % 7 == 0) begin s[XLEN/2-1] = 1'b1; rec = 1'b1; end
            op(m[1] ? "R5/R6 random half" : "R3/R4 random full", m, s, c, im, rec,
               ref_perm(m, s, c, im));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule